// File: doc/BRIEF.md
# Instruction Fetch Unit

This block holds the program counter of a simple single-issue processor and reads one 32-bit instruction per clock from a word-organised instruction ROM. A PC value arrives from later stages and is captured only while an active-low load enable is held low. The captured value is used for the fetch on the following clock edge, so a new PC becomes visible one cycle before the instruction it selects.

The ROM word passes through an output register that serves as the instruction register in front of decode. The PC of that instruction and the sequential successor PC+4 are presented in the same cycle as the instruction. The memory read enable is tied permanently active, so the synchronous active-high reset always clears the instruction register. The same reset also clears the program counter. An all-zero instruction word decodes as no operation class. The ROM is an internal array that the testbench fills before reset is released.

Top module: `ifetch_unit`

## Requirements
- R1: When `pc_load_n` is 0 and `rst` is 0 at a rising edge, the internal PC takes the value of `pc_in` at that edge.
- R2: When `pc_load_n` is 1 and `rst` is 0, the internal PC holds. Repeated fetches then return the same word and the same `pc_cur`.
- R3: At each rising edge without reset, `instr` takes the ROM word selected by the internal PC as it stood before that edge, and `pc_cur` takes that PC. A value loaded at edge k therefore appears on `pc_cur` and selects `instr` after edge k+1.
- R4: `pc_next` always equals `pc_cur + 4` modulo 2^32, so 0xFFFFFFFC is followed by 0x00000000.
- R5: The ROM word index is PC bits [13:2] (4096 words). Bits [1:0] and [31:14] do not change which word is fetched, but they are kept in `pc_cur`.
- R6: A rising edge with `rst` = 1 clears the internal PC, `instr` and `pc_cur` to 0, and `pc_next` then reads 4. Reset takes priority over a simultaneous load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for PC and instruction register |
| rst | input | 1 | Synchronous active-high reset of PC and instruction store |
| pc_load_n | input | 1 | Active-low PC load enable |
| pc_in | input | 32 | PC value from later stages |
| instr | output | 32 | Registered instruction word |
| pc_cur | output | 32 | Byte address of the instruction on `instr` |
| pc_next | output | 32 | `pc_cur` + 4 |

## Verification
The embedded properties check on every cycle that a low load enable captures `pc_in`, that a high one holds the PC, and that `pc_cur` trails the PC register by one edge. They also check that `instr` matches the ROM word addressed by `pc_cur`, and that reset clears the outputs. The bench scenarios are needed for the two-edge latency from a load to the fetched word. They also cover reset priority over a load, the wrap of `pc_next` at the top of the address space, and aliasing through the ignored address bits, all against an independent model.

// File: rtl/ifetch_unit.sv
module ifetch_unit #(
  parameter int WORD_W  = 32,
  parameter int DEPTH   = 4096,
  parameter int PC_STEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pc_load_n,
  input  logic [WORD_W-1:0] pc_in,
  output logic [WORD_W-1:0] instr,
  output logic [WORD_W-1:0] pc_cur,
  output logic [WORD_W-1:0] pc_next
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int OFF_W = $clog2(PC_STEP);

  logic [WORD_W-1:0] rom [DEPTH];
  logic [WORD_W-1:0] pc_q;
  logic [WORD_W-1:0] ir_q;
  logic [WORD_W-1:0] fpc_q;
  logic [IDX_W-1:0]  idx;

  initial begin
    for (int i = 0; i < DEPTH; i++) rom[i] = '0;
  end

  assign idx = pc_q[OFF_W +: IDX_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      ir_q  <= '0;
      fpc_q <= '0;
    end else begin
      if (!pc_load_n) pc_q <= pc_in;
      ir_q  <= rom[idx];
      fpc_q <= pc_q;
    end
  end

  assign instr   = ir_q;
  assign pc_cur  = fpc_q;
  assign pc_next = fpc_q + WORD_W'(PC_STEP);

  p_load_r1: assert property (@(posedge clk) disable iff (rst)
    !pc_load_n |=> pc_q == $past(pc_in));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    pc_load_n |=> $stable(pc_q));

  p_follow_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pc_cur == $past(pc_q));

  p_fetch_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> instr == rom[pc_cur[OFF_W +: IDX_W]]);

  p_clear_r6: assert property (@(posedge clk)
    rst |=> (instr == '0 && pc_cur == '0 && pc_q == '0));
endmodule

// File: tb/ifetch_unit_bench.sv
module ifetch_unit_bench;
  localparam int DEPTH = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pc_load_n = 1'b1;
  logic [31:0] pc_in = '0;
  logic [31:0] instr, pc_cur, pc_next;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [31:0] rom_m [DEPTH];
  logic [31:0] m_pc, m_ir, m_fpc;

  always #4 clk = ~clk;

  ifetch_unit u_ifetch_unit (
    .clk(clk), .rst(rst), .pc_load_n(pc_load_n), .pc_in(pc_in),
    .instr(instr), .pc_cur(pc_cur), .pc_next(pc_next)
  );

  function automatic logic [31:0] word_of(int i);
    return (32'(i) * 32'h9E37_79B1) ^ 32'h5A00_00C3 ^ {20'h0, 12'(i)};
  endfunction

  function automatic int index_of(logic [31:0] a);
    return int'(a[13:2]);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic r, logic ld_n, logic [31:0] p, string tag);
    logic [31:0] nir, nfpc, npc;
    rst = r; pc_load_n = ld_n; pc_in = p;
    @(posedge clk);
    nir  = r ? 32'h0 : rom_m[index_of(m_pc)];
    nfpc = r ? 32'h0 : m_pc;
    npc  = r ? 32'h0 : (!ld_n ? p : m_pc);
    m_ir = nir; m_fpc = nfpc; m_pc = npc;
    @(negedge clk);
    chk({tag, " instr"}, instr, m_ir);
    chk({tag, " pc_cur"}, pc_cur, m_fpc);
    chk({"R4 ", tag, " pc_next"}, pc_next, m_fpc + 32'd4);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_pc = '0; m_ir = '0; m_fpc = '0;
    #1;
    for (int i = 0; i < DEPTH; i++) begin
      rom_m[i] = word_of(i);
      u_ifetch_unit.rom[i] = word_of(i);
    end
    @(negedge clk);
    cyc(1'b1, 1'b1, 32'h0, "R6 reset");
    cyc(1'b1, 1'b1, 32'h0, "R6 reset");
    chk("R6 reset pc_next", pc_next, 32'd4);

    cyc(1'b0, 1'b0, 32'h0000_0100, "R1 load");
    cyc(1'b0, 1'b1, 32'h0, "R3 fetch after load");
    chk("R3 loaded word", instr, word_of(32'h100 >> 2));
    chk("R3 loaded pc", pc_cur, 32'h0000_0100);

    cyc(1'b0, 1'b1, 32'hDEAD_BEEF, "R2 hold");
    cyc(1'b0, 1'b1, 32'h1234_5678, "R2 hold");
    chk("R2 held word", instr, word_of(32'h100 >> 2));

    for (int k = 0; k < 8; k++) cyc(1'b0, 1'b0, pc_next, "R3 sequential");

    cyc(1'b0, 1'b0, 32'h0000_0053, "R5 misaligned");
    cyc(1'b0, 1'b0, 32'hABCD_4053, "R5 high bits");
    chk("R5 low bits ignored", instr, word_of(32'h50 >> 2));
    chk("R5 pc kept", pc_cur, 32'h0000_0053);
    cyc(1'b0, 1'b1, 32'h0, "R5 alias");
    chk("R5 high bits ignored", instr, word_of(32'h50 >> 2));
    chk("R5 pc kept high", pc_cur, 32'hABCD_4053);

    cyc(1'b0, 1'b0, 32'hFFFF_FFFC, "R4 top");
    cyc(1'b0, 1'b1, 32'h0, "R4 top");
    chk("R4 wrap", pc_next, 32'h0000_0000);
    chk("R3 top word", instr, word_of(DEPTH - 1));

    cyc(1'b1, 1'b0, 32'h0000_0800, "R6 reset over load");
    cyc(1'b0, 1'b1, 32'h0, "R6 pc cleared");
    chk("R6 pc cleared", pc_cur, 32'h0);
    chk("R6 word zero", instr, word_of(0));

    for (int k = 0; k < 3000; k++) begin
      int sel = int'($urandom % 8);
      if (sel == 0)      cyc(1'b0, 1'b1, $urandom, "R2 random hold");
      else if (sel == 1) cyc(1'b0, 1'b0, $urandom, "R1 random jump");
      else if (sel == 7 && k % 97 == 0) cyc(1'b1, $urandom % 2 == 0, $urandom, "R6 random reset");
      else               cyc(1'b0, 1'b0, pc_next, "R3 random seq");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule